// File: doc/BRIEF.md
# Isochronous Endpoint Buffer-Swap Controller

This block manages one full-speed isochronous endpoint that runs double-buffered. Two packet buffer descriptors (address and count pairs) serve the endpoint. A single registered select bit tells the packet engine which descriptor the serial side fills or drains, and the application owns the other one. Each completed transaction flips the select in hardware, so the swap needs no software action. Each completion also raises a per-direction completion flag. A CRC error on a received packet raises a sticky error flag as well, because the packet still counts as delivered.

Software reaches the block through one write port of `CFG_W` bits. A write loads the endpoint type, the status pair and the direction. The same write can flip either toggle bit and can clear the flags. The endpoint serves one direction only, so an endpoint that needs both directions uses two instances. A read word reflects the full state of the block.

Top module: `iso_bufswap_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every bit of `cfg_rd` is 0, and `buf_sel`, `done_rx`, `done_tx` and `err_flag` are 0.
- R2: A completion strobe is accepted only when the type field is 2'b10 and the status field is 2'b11. In every other case the strobe changes no flag and no toggle bit, and this includes the illegal status values 2'b01 and 2'b10.
- R3: An accepted completion while the direction bit is 0 (receive) sets `done_rx` and flips the receive toggle (`cfg_rd[5]`). The transmit toggle is left unchanged.
- R4: An accepted completion while the direction bit is 1 (transmit) sets `done_tx` and flips the transmit toggle (`cfg_rd[6]`). The receive toggle is left unchanged.
- R5: The type, status and direction fields (`cfg_rd[1:0]`, `cfg_rd[3:2]`, `cfg_rd[4]`) change only on a software write and never on a completion.
- R6: An accepted receive completion that carries a CRC error or an overrun still sets `done_rx` and still flips the receive toggle. A CRC error also sets `err_flag`. An overrun alone does not set `err_flag`.
- R7: In a write word, a 1 in bit 5 flips the receive toggle and a 1 in bit 6 flips the transmit toggle. A 0 in either bit leaves that toggle alone. A software flip and a hardware flip in the same cycle cancel out.
- R8: A write with bit 7 at 0 clears `done_rx`, with bit 8 at 0 clears `done_tx`, and with bit 9 at 0 clears `err_flag`. A 1 in any of these bits has no effect. A hardware set in the same cycle as a software clear wins.
- R9: `buf_sel` is registered. It equals the toggle of the direction held after the clock edge, so it changes in the cycle after the completion or the write.
- R10: A CRC error on an accepted transmit completion does not set `err_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | CFG_W | Write word: [1:0] type, [3:2] status, [4] direction, [5]/[6] toggle flips, [7]/[8]/[9] flag keep bits |
| xfer_done | input | 1 | Transaction-complete strobe from the packet engine |
| crc_err | input | 1 | CRC error on the completing packet |
| ovr_err | input | 1 | Buffer overrun on the completing packet |
| buf_sel | output | 1 | Descriptor used by the serial side (0 or 1); the application owns the other |
| done_rx | output | 1 | Receive-complete flag |
| done_tx | output | 1 | Transmit-complete flag |
| err_flag | output | 1 | Sticky error flag |
| cfg_rd | output | CFG_W | Read word in the same bit layout as the write word |

## Verification
Two pairs of events can fall in the same cycle. In the first, a hardware completion meets a software toggle flip on the same direction. In the second, a hardware flag set meets a software flag clear. The bench forces both on purpose: it asserts `xfer_done` together with `sw_wr` carrying a flip bit or a clear bit. It then expects the toggle to stay unchanged and the flag to stay set. The randomized phase reaches the same collisions and judges every cycle against a behavioural model. That model applies the completion first and then the software write, using the configuration in effect before that write.

// File: rtl/iso_ep_pkg.sv
package iso_ep_pkg;
  localparam int CFG_W   = 10;
  localparam int TYPE_W  = 2;
  localparam int STAT_W  = 2;
  localparam int B_TYPE  = 0;
  localparam int B_STAT  = B_TYPE + TYPE_W;
  localparam int B_DIR   = B_STAT + STAT_W;
  localparam int B_TRX   = B_DIR + 1;
  localparam int B_TTX   = B_TRX + 1;
  localparam int B_FRX   = B_TTX + 1;
  localparam int B_FTX   = B_FRX + 1;
  localparam int B_ERR   = B_FTX + 1;
  localparam logic [TYPE_W-1:0] TYPE_ISO   = 2'b10;
  localparam logic [STAT_W-1:0] STAT_VALID = 2'b11;
endpackage

// File: rtl/iso_ep_cfg.sv
module iso_ep_cfg
  import iso_ep_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CFG_W-1:0]  wdata,
  output logic [TYPE_W-1:0] ep_type,
  output logic [STAT_W-1:0] ep_stat,
  output logic              ep_dir,
  output logic              active
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ep_type <= '0;
      ep_stat <= '0;
      ep_dir  <= 1'b0;
    end else if (wr) begin
      ep_type <= wdata[B_TYPE +: TYPE_W];
      ep_stat <= wdata[B_STAT +: STAT_W];
      ep_dir  <= wdata[B_DIR];
    end
  end

  assign active = (ep_type == TYPE_ISO) && (ep_stat == STAT_VALID);

  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable({ep_type, ep_stat, ep_dir}));
endmodule

// File: rtl/iso_ep_toggle.sv
module iso_ep_toggle (
  input  logic clk,
  input  logic rst,
  input  logic hw_rx,
  input  logic hw_tx,
  input  logic sw_rx,
  input  logic sw_tx,
  input  logic dir_nxt,
  output logic tog_rx,
  output logic tog_tx,
  output logic buf_sel
);
  logic nxt_rx, nxt_tx;

  always_comb begin
    nxt_rx = tog_rx ^ hw_rx ^ sw_rx;
    nxt_tx = tog_tx ^ hw_tx ^ sw_tx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_rx  <= 1'b0;
      tog_tx  <= 1'b0;
      buf_sel <= 1'b0;
    end else begin
      tog_rx  <= nxt_rx;
      tog_tx  <= nxt_tx;
      buf_sel <= dir_nxt ? nxt_tx : nxt_rx;
    end
  end

  p_hw_flip_r3: assert property (@(posedge clk) disable iff (rst)
    (hw_rx && !sw_rx) |=> (tog_rx != $past(tog_rx)));
  p_hw_flip_r4: assert property (@(posedge clk) disable iff (rst)
    (hw_tx && !sw_tx) |=> (tog_tx != $past(tog_tx)));
  p_cancel_r7: assert property (@(posedge clk) disable iff (rst)
    (hw_rx && sw_rx) |=> $stable(tog_rx));
endmodule

// File: rtl/iso_ep_flags.sv
module iso_ep_flags (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic set_rx,
  input  logic set_tx,
  input  logic set_err,
  input  logic keep_rx,
  input  logic keep_tx,
  input  logic keep_err,
  output logic flag_rx,
  output logic flag_tx,
  output logic flag_err
);
  logic clr_rx, clr_tx, clr_err;

  always_comb begin
    clr_rx  = wr && !keep_rx;
    clr_tx  = wr && !keep_tx;
    clr_err = wr && !keep_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_rx  <= 1'b0;
      flag_tx  <= 1'b0;
      flag_err <= 1'b0;
    end else begin
      flag_rx  <= set_rx  || (flag_rx  && !clr_rx);
      flag_tx  <= set_tx  || (flag_tx  && !clr_tx);
      flag_err <= set_err || (flag_err && !clr_err);
    end
  end

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    set_rx |=> flag_rx);
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (wr && !keep_tx && !set_tx) |=> !flag_tx);
endmodule

// File: rtl/iso_bufswap_ctrl.sv
module iso_bufswap_ctrl
  import iso_ep_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_wr,
  input  logic [CFG_W-1:0] sw_wdata,
  input  logic             xfer_done,
  input  logic             crc_err,
  input  logic             ovr_err,
  output logic             buf_sel,
  output logic             done_rx,
  output logic             done_tx,
  output logic             err_flag,
  output logic [CFG_W-1:0] cfg_rd
);
  logic [TYPE_W-1:0] ep_type;
  logic [STAT_W-1:0] ep_stat;
  logic ep_dir, active, accept, hw_rx, hw_tx, tog_rx, tog_tx, dir_nxt;

  iso_ep_cfg u_cfg (
    .clk(clk), .rst(rst), .wr(sw_wr), .wdata(sw_wdata),
    .ep_type(ep_type), .ep_stat(ep_stat), .ep_dir(ep_dir), .active(active)
  );

  always_comb begin
    accept  = xfer_done && active;
    hw_rx   = accept && !ep_dir;
    hw_tx   = accept && ep_dir;
    dir_nxt = sw_wr ? sw_wdata[B_DIR] : ep_dir;
  end

  iso_ep_toggle u_tog (
    .clk(clk), .rst(rst), .hw_rx(hw_rx), .hw_tx(hw_tx),
    .sw_rx(sw_wr && sw_wdata[B_TRX]), .sw_tx(sw_wr && sw_wdata[B_TTX]),
    .dir_nxt(dir_nxt), .tog_rx(tog_rx), .tog_tx(tog_tx), .buf_sel(buf_sel)
  );

  iso_ep_flags u_flg (
    .clk(clk), .rst(rst), .wr(sw_wr),
    .set_rx(hw_rx), .set_tx(hw_tx), .set_err(hw_rx && crc_err),
    .keep_rx(sw_wdata[B_FRX]), .keep_tx(sw_wdata[B_FTX]), .keep_err(sw_wdata[B_ERR]),
    .flag_rx(done_rx), .flag_tx(done_tx), .flag_err(err_flag)
  );

  always_comb begin
    cfg_rd                    = '0;
    cfg_rd[B_TYPE +: TYPE_W]  = ep_type;
    cfg_rd[B_STAT +: STAT_W]  = ep_stat;
    cfg_rd[B_DIR]             = ep_dir;
    cfg_rd[B_TRX]             = tog_rx;
    cfg_rd[B_TTX]             = tog_tx;
    cfg_rd[B_FRX]             = done_rx;
    cfg_rd[B_FTX]             = done_tx;
    cfg_rd[B_ERR]             = err_flag;
  end

  p_ignore_r2: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !active && !sw_wr) |=> $stable(cfg_rd));
  p_crc_err_r6: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && active && !ep_dir && crc_err) |=> err_flag);
  p_ovr_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && ovr_err && !crc_err && !err_flag) |=> !err_flag);
  p_in_crc_r10: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && ep_dir && crc_err && !err_flag) |=> !err_flag);
endmodule

// File: tb/test_iso_bufswap_ctrl.sv
module test_iso_bufswap_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;

  logic clk = 1'b0, rst = 1'b1, sw_wr = 1'b0, xfer_done = 1'b0, crc_err = 1'b0, ovr_err = 1'b0;
  logic [W-1:0] sw_wdata = '0;
  logic buf_sel, done_rx, done_tx, err_flag;
  logic [W-1:0] cfg_rd;

  int tests = 0, fails = 0;
  bit finished = 0;

  int m_type, m_stat, m_dir, m_trx, m_ttx, m_frx, m_ftx, m_err, m_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_bufswap_ctrl i_iso_bufswap_ctrl (
    .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .xfer_done(xfer_done),
    .crc_err(crc_err), .ovr_err(ovr_err), .buf_sel(buf_sel), .done_rx(done_rx),
    .done_tx(done_tx), .err_flag(err_flag), .cfg_rd(cfg_rd)
  );

  // behavioural reference: completion first (old config), then software write
  always @(posedge clk) begin
    if (rst) begin
      m_type = 0; m_stat = 0; m_dir = 0; m_trx = 0; m_ttx = 0;
      m_frx = 0; m_ftx = 0; m_err = 0; m_sel = 0;
    end else begin
      int hrx, htx;
      hrx = (xfer_done && m_type == 2 && m_stat == 3 && m_dir == 0) ? 1 : 0;
      htx = (xfer_done && m_type == 2 && m_stat == 3 && m_dir == 1) ? 1 : 0;
      if (hrx) m_trx = 1 - m_trx;
      if (htx) m_ttx = 1 - m_ttx;
      if (sw_wr && sw_wdata[5]) m_trx = 1 - m_trx;
      if (sw_wr && sw_wdata[6]) m_ttx = 1 - m_ttx;
      if (sw_wr && !sw_wdata[7]) m_frx = 0;
      if (sw_wr && !sw_wdata[8]) m_ftx = 0;
      if (sw_wr && !sw_wdata[9]) m_err = 0;
      if (hrx) m_frx = 1;
      if (htx) m_ftx = 1;
      if (hrx && crc_err) m_err = 1;
      if (sw_wr) begin
        m_type = int'(sw_wdata[1:0]); m_stat = int'(sw_wdata[3:2]); m_dir = int'(sw_wdata[4]);
      end
      m_sel = (m_dir == 1) ? m_ttx : m_trx;
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    cmp("R5 type", int'(cfg_rd[1:0]), m_type);
    cmp("R5 status", int'(cfg_rd[3:2]), m_stat);
    cmp("R5 dir", int'(cfg_rd[4]), m_dir);
    cmp("R3 rx toggle", int'(cfg_rd[5]), m_trx);
    cmp("R4 tx toggle", int'(cfg_rd[6]), m_ttx);
    cmp("R3 done_rx", int'(done_rx), m_frx);
    cmp("R4 done_tx", int'(done_tx), m_ftx);
    cmp("R6 err_flag", int'(err_flag), m_err);
    cmp("R8 rd flags", int'(cfg_rd[9:7]), m_err*4 + m_ftx*2 + m_frx);
    cmp("R9 buf_sel", int'(buf_sel), m_sel);
  endtask

  function automatic logic [W-1:0] mk(int ty, int st, int dr, int frx_t, int ftx_t,
                                      int keep_rx, int keep_tx, int keep_err);
    logic [W-1:0] w;
    w[1:0] = 2'(ty); w[3:2] = 2'(st); w[4] = 1'(dr); w[5] = 1'(frx_t); w[6] = 1'(ftx_t);
    w[7] = 1'(keep_rx); w[8] = 1'(keep_tx); w[9] = 1'(keep_err);
    return w;
  endfunction

  task automatic cyc(input logic wr, input logic [W-1:0] wd, input logic dn,
                     input logic ce, input logic oe);
    sw_wr = wr; sw_wdata = wd; xfer_done = dn; crc_err = ce; ovr_err = oe;
    @(negedge clk);
    sw_wr = 0; xfer_done = 0; crc_err = 0; ovr_err = 0;
    compare_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 reset cfg_rd", int'(cfg_rd), 0);
    cmp("R1 reset outputs", int'({buf_sel, done_rx, done_tx, err_flag}), 0);
    rst = 0;
    cyc(1, mk(2,3,0,0,0,1,1,1), 0, 0, 0);
    cyc(0, '0, 1, 0, 0);
    cmp("R3 rx done set", int'(done_rx), 1);
    cmp("R9 buf_sel after rx done", int'(buf_sel), 1);
    cyc(0, '0, 1, 1, 0);
    cmp("R6 crc sets err", int'(err_flag), 1);
    cmp("R6 crc still swaps", int'(buf_sel), 0);
    cyc(1, mk(2,3,0,0,0,0,1,0), 0, 0, 0);
    cmp("R8 clear by zero", int'({done_rx, err_flag}), 0);
    cyc(0, '0, 1, 0, 1);
    cmp("R6 overrun no err", int'({done_rx, err_flag}), 2);
    cyc(1, mk(2,3,0,0,0,0,1,1), 1, 0, 0);
    cmp("R8 hw set beats clear", int'(done_rx), 1);
    cyc(1, mk(2,3,0,1,0,1,1,1), 0, 0, 0);
    cmp("R7 sw flip", int'(cfg_rd[5]), 1);
    cyc(1, mk(2,3,0,1,0,1,1,1), 1, 0, 0);
    cmp("R7 hw and sw cancel", int'(cfg_rd[5]), 1);
    cyc(1, mk(2,1,0,0,0,0,1,1), 0, 0, 0);
    cyc(0, '0, 1, 1, 0);
    cmp("R2 illegal status ignored", int'({cfg_rd[5], done_rx, err_flag}), 4);
    cyc(1, mk(0,3,0,0,0,1,1,1), 1, 0, 0);
    cyc(0, '0, 1, 0, 0);
    cmp("R2 non-iso type ignored", int'(cfg_rd[5]), 1);
    cyc(1, mk(2,3,1,0,0,1,1,1), 0, 0, 0);
    cyc(0, '0, 1, 1, 0);
    cmp("R4 tx done set", int'(done_tx), 1);
    cmp("R10 tx crc no err", int'(err_flag), 0);
    cmp("R5 status kept valid", int'(cfg_rd[3:2]), 3);
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] wd;
      wd = W'($urandom);
      if ($urandom_range(0, 3) != 0) wd[1:0] = 2'b10;
      if ($urandom_range(0, 3) != 0) wd[3:2] = 2'b11;
      cyc(($urandom_range(0, 3) == 0), wd, 1'($urandom), 1'($urandom), 1'($urandom));
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule